// File: doc/BRIEF.md
# Zero Run-Length Codec for 16-bit Feature Maps

This block shrinks streams of 16-bit feature-map values on their way to external memory by squeezing out runs of zeros, and rebuilds them on the way back. The packing side accepts one value per cycle together with an end-of-stream marker. It describes the stream as pairs. Each pair holds a 5-bit count of the zeros that came before a value, and then that value verbatim in 16 bits. Three pairs go into each 64-bit word, and the top bit of the word flags the final word of a stream.

The unpacking side takes those 64-bit words and produces the original values again, one per cycle, with the end marker on the final value. While it expands a run it holds off the word stream. Both sides use valid/ready handshakes. They are brought out separately, so a system can place memory between them, or a bench can loop the word stream straight back.

Top module: `zrl_codec`

## Requirements
- R1: A word holds pair slot k (k = 0, 1, 2) in bits [21k+20 : 21k]. Within a pair, the zero count sits in the low 5 bits and the value in the upper 16 bits. Bit 63 is 1 only on the final word of a stream.
- R2: A non-zero input value produces a pair of (number of zeros since the previous pair, value). Zeros that are not last only raise that count.
- R3: A zero that arrives while 31 zeros are already pending, and is not last, produces the pair (31, 0). The count then restarts from zero.
- R4: Pairs fill slots 0, 1, 2 in order. A word that is not final carries three pairs, and none of them is (0, 0).
- R5: In the final word, slots after the final pair are (0, 0). A stream whose last value is zero ends with the pair (trailing zero count, 0). When that count would be 32, the stream ends with (30, 0) and then (1, 0).
- R6: After reset, and after each final word, the packer starts with a zero count of 0 and slot 0, so every stream is encoded independently of the one before it.
- R7: The unpacker emits the zeros of a pair, then its value, one item per cycle. It skips padding slots. When the final pair has value 0, it emits only that pair's zeros, and the end marker goes on the last of them.
- R8: On both sides, an output that is offered and not taken stays unchanged. The unpacker takes no new word until the current word is fully expanded.
- R9: Feeding the packer's words to the unpacker gives back exactly the input values, in order, with the end marker only on the last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_valid | input | 1 | Input value offered to the packer |
| enc_ready | output | 1 | Packer takes the offered value |
| enc_data | input | 16 | Input value |
| enc_last | input | 1 | Offered value ends the stream |
| wout_valid | output | 1 | Packed word available |
| wout_ready | input | 1 | Consumer takes the packed word |
| wout_data | output | 64 | Packed word |
| win_valid | input | 1 | Packed word offered to the unpacker |
| win_ready | output | 1 | Unpacker takes the offered word |
| win_data | input | 64 | Packed word to expand |
| dec_valid | output | 1 | Rebuilt value available |
| dec_ready | input | 1 | Consumer takes the rebuilt value |
| dec_data | output | 16 | Rebuilt value |
| dec_last | output | 1 | Rebuilt value ends the stream |

## Verification
The assertions check several properties on every cycle. Offered words and values hold steady under back-pressure. A word that is not final is always full of real pairs, and a final word always carries a pair in slot 0. The packer's count and slot return to zero after a final word, and the unpacker goes quiet after handing over an end marker. The scenarios cover what only a whole stream can show: zero-count saturation at 31, the two-pair tail for 32 trailing zeros, padding of partly filled final words, exact bit layout against a separate model, and lossless round trips under random back-pressure.

// File: rtl/zrl_pkg.sv
package zrl_pkg;
  parameter int RUN_W    = 5;
  parameter int LVL_W    = 16;
  parameter int PAIR_W   = RUN_W + LVL_W;
  parameter int PAIRS    = 3;
  parameter int BODY_W   = PAIRS * PAIR_W;
  parameter int WORD_W   = BODY_W + 1;
  parameter int SLOT_W   = $clog2(PAIRS);
  parameter int RUN_MAX  = (1 << RUN_W) - 1;

  typedef logic [PAIR_W-1:0] pair_t;

  function automatic pair_t pack_pair(logic [RUN_W-1:0] r, logic [LVL_W-1:0] l);
    return {l, r};
  endfunction

  function automatic logic [RUN_W-1:0] pair_run(pair_t p);
    return p[RUN_W-1:0];
  endfunction

  function automatic logic [LVL_W-1:0] pair_lvl(pair_t p);
    return p[PAIR_W-1:RUN_W];
  endfunction

  function automatic pair_t pick_pair(logic [BODY_W-1:0] body, int k);
    if (k >= PAIRS) return '0;
    return body[k*PAIR_W +: PAIR_W];
  endfunction
endpackage

// File: rtl/zrl_pack.sv
module zrl_pack
  import zrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [LVL_W-1:0]  in_data,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data
);
  logic [RUN_W-1:0]  run_q;
  logic [SLOT_W-1:0] slot_q;
  logic [BODY_W-1:0] asm_q, asm_next;
  logic              tail_q;
  logic              wv_q;
  logic [WORD_W-1:0] wd_q;

  // named events for the checks below
  logic              out_free, acc, is_zero, at_max;
  logic              emit, set_tail, count_up, p_final, word_done, final_done;
  logic [RUN_W-1:0]  p_run;
  logic [LVL_W-1:0]  p_lvl;

  assign out_free   = !wv_q || out_ready;
  assign in_ready   = out_free && !tail_q;
  assign acc        = in_valid && in_ready;
  assign is_zero    = (in_data == '0);
  assign at_max     = (run_q == RUN_W'(RUN_MAX));
  assign out_valid  = wv_q;
  assign out_data   = wd_q;

  always_comb begin
    emit     = 1'b0;
    set_tail = 1'b0;
    count_up = 1'b0;
    p_run    = '0;
    p_lvl    = '0;
    p_final  = 1'b0;
    if (tail_q) begin
      emit    = out_free;
      p_run   = RUN_W'(1);
      p_final = 1'b1;
    end else if (acc) begin
      if (!is_zero) begin
        emit    = 1'b1;
        p_run   = run_q;
        p_lvl   = in_data;
        p_final = in_last;
      end else if (in_last) begin
        emit = 1'b1;
        if (at_max) begin
          p_run    = RUN_W'(RUN_MAX - 1);
          set_tail = 1'b1;
        end else begin
          p_run   = run_q + RUN_W'(1);
          p_final = 1'b1;
        end
      end else if (at_max) begin
        emit  = 1'b1;
        p_run = run_q;
      end else begin
        count_up = 1'b1;
      end
    end
  end

  always_comb begin
    asm_next = asm_q;
    for (int k = 0; k < PAIRS; k++) begin
      if (slot_q == SLOT_W'(k)) asm_next[k*PAIR_W +: PAIR_W] = pack_pair(p_run, p_lvl);
    end
  end

  assign word_done  = emit && (p_final || slot_q == SLOT_W'(PAIRS - 1));
  assign final_done = word_done && p_final;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= '0;
      slot_q <= '0;
      asm_q  <= '0;
      tail_q <= 1'b0;
      wv_q   <= 1'b0;
      wd_q   <= '0;
    end else begin
      if (emit)          run_q <= '0;
      else if (count_up) run_q <= run_q + RUN_W'(1);

      if (set_tail)              tail_q <= 1'b1;
      else if (tail_q && emit)   tail_q <= 1'b0;

      if (word_done) begin
        wv_q   <= 1'b1;
        wd_q   <= {p_final, asm_next};
        asm_q  <= '0;
        slot_q <= '0;
      end else begin
        if (emit) begin
          asm_q  <= asm_next;
          slot_q <= slot_q + SLOT_W'(1);
        end
        if (out_ready) wv_q <= 1'b0;
      end
    end
  end

  AST_PACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wv_q && !out_ready |=> wv_q && $stable(wd_q)); // R8
  AST_PACK_FULL_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    wv_q && !wd_q[WORD_W-1] |-> pick_pair(wd_q[BODY_W-1:0], 0) != '0 &&
      pick_pair(wd_q[BODY_W-1:0], 1) != '0 && pick_pair(wd_q[BODY_W-1:0], 2) != '0); // R4
  AST_PACK_FINAL_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    wv_q && wd_q[WORD_W-1] |-> pick_pair(wd_q[BODY_W-1:0], 0) != '0); // R5
  AST_PACK_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    final_done |=> run_q == '0 && slot_q == '0 && !tail_q); // R6
endmodule

// File: rtl/zrl_unpack.sv
module zrl_unpack
  import zrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [LVL_W-1:0]  out_data,
  output logic              out_last
);
  logic              busy_q;
  logic [WORD_W-1:0] word_q;
  logic [SLOT_W-1:0] slot_q;
  logic [RUN_W-1:0]  zcnt_q;

  // named events for the checks below
  pair_t             cur;
  logic [RUN_W-1:0]  cur_run;
  logic [LVL_W-1:0]  cur_lvl;
  logic              last_slot, next_empty, is_final, drop;
  logic              zero_phase, last_zero, fire, skip, step, word_end, take;

  assign cur        = pick_pair(word_q[BODY_W-1:0], int'(slot_q));
  assign cur_run    = pair_run(cur);
  assign cur_lvl    = pair_lvl(cur);
  assign last_slot  = (slot_q == SLOT_W'(PAIRS - 1));
  assign next_empty = last_slot || (pick_pair(word_q[BODY_W-1:0], int'(slot_q) + 1) == '0);
  assign is_final   = word_q[WORD_W-1] && next_empty;
  assign drop       = is_final && (cur_lvl == '0);
  assign zero_phase = (zcnt_q < cur_run);
  assign last_zero  = zero_phase && (zcnt_q == cur_run - RUN_W'(1));

  assign out_valid  = busy_q && (zero_phase || !drop);
  assign out_data   = zero_phase ? '0 : cur_lvl;
  assign out_last   = is_final && (zero_phase ? (drop && last_zero) : 1'b1);
  assign in_ready   = !busy_q;

  assign fire     = out_valid && out_ready;
  assign skip     = busy_q && !zero_phase && drop;
  assign step     = (fire && (!zero_phase || (drop && last_zero))) || skip;
  assign word_end = step && (is_final || last_slot);
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      word_q <= '0;
      slot_q <= '0;
      zcnt_q <= '0;
    end else if (take) begin
      busy_q <= 1'b1;
      word_q <= in_data;
      slot_q <= '0;
      zcnt_q <= '0;
    end else if (step) begin
      zcnt_q <= '0;
      if (word_end) busy_q <= 1'b0;
      else          slot_q <= slot_q + SLOT_W'(1);
    end else if (fire) begin
      zcnt_q <= zcnt_q + RUN_W'(1);
    end
  end

  AST_UNPACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last)); // R8
  AST_UNPACK_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    fire && out_last |=> !out_valid); // R7
  AST_UNPACK_WORD_DONE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    word_end |=> in_ready); // R8
endmodule

// File: rtl/zrl_codec.sv
module zrl_codec
  import zrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enc_valid,
  output logic              enc_ready,
  input  logic [LVL_W-1:0]  enc_data,
  input  logic              enc_last,
  output logic              wout_valid,
  input  logic              wout_ready,
  output logic [WORD_W-1:0] wout_data,
  input  logic              win_valid,
  output logic              win_ready,
  input  logic [WORD_W-1:0] win_data,
  output logic              dec_valid,
  input  logic              dec_ready,
  output logic [LVL_W-1:0]  dec_data,
  output logic              dec_last
);
  zrl_pack i_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (enc_valid),
    .in_ready  (enc_ready),
    .in_data   (enc_data),
    .in_last   (enc_last),
    .out_valid (wout_valid),
    .out_ready (wout_ready),
    .out_data  (wout_data)
  );

  zrl_unpack i_unpack (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (win_valid),
    .in_ready  (win_ready),
    .in_data   (win_data),
    .out_valid (dec_valid),
    .out_ready (dec_ready),
    .out_data  (dec_data),
    .out_last  (dec_last)
  );
endmodule

// File: tb/test_zrl_codec.sv
`timescale 1ns/1ps
module test_zrl_codec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enc_valid = 1'b0, enc_last = 1'b0;
  logic [15:0] enc_data = '0;
  logic        enc_ready;
  logic        wout_valid, wout_ready, win_ready;
  logic [63:0] wout_data;
  logic        dec_valid, dec_last;
  logic        dec_ready = 1'b1;
  logic [15:0] dec_data;

  int checks = 0, fails = 0;
  bit throttle_en = 1'b0;

  always #10 clk = ~clk;

  zrl_codec i_zrl_codec (
    .clk(clk), .rst_n(rst_n),
    .enc_valid(enc_valid), .enc_ready(enc_ready), .enc_data(enc_data), .enc_last(enc_last),
    .wout_valid(wout_valid), .wout_ready(wout_ready), .wout_data(wout_data),
    .win_valid(wout_valid), .win_ready(win_ready), .win_data(wout_data),
    .dec_valid(dec_valid), .dec_ready(dec_ready), .dec_data(dec_data), .dec_last(dec_last)
  );
  assign wout_ready = win_ready;

  // scoreboard queues
  logic [63:0] exp_w[$];
  string       exp_wtag[$];
  logic [16:0] exp_v[$];
  string       exp_vtag[$];
  int          stim[$];

  // independent encoding model
  int          m_run, m_slot;
  logic [63:0] m_acc;

  task automatic put_pair(int r, int l, bit f, string tag);
    logic [63:0] p;
    p = (64'(l) << 5) | 64'(r);
    m_acc = m_acc | (p << (21 * m_slot));
    if (f || m_slot == 2) begin
      if (f) m_acc[63] = 1'b1;
      exp_w.push_back(m_acc);
      exp_wtag.push_back(tag);
      m_acc = '0;
      m_slot = 0;
    end else begin
      m_slot++;
    end
  endtask

  task automatic model(string wtag, string vtag);
    m_run = 0; m_slot = 0; m_acc = '0;
    for (int i = 0; i < stim.size(); i++) begin
      bit last;
      last = (i == stim.size() - 1);
      exp_v.push_back({last, 16'(stim[i])});
      exp_vtag.push_back(vtag);
      if (stim[i] != 0) begin
        put_pair(m_run, stim[i], last, wtag); m_run = 0;
      end else if (last) begin
        if (m_run == 31) begin put_pair(30, 0, 0, wtag); put_pair(1, 0, 1, wtag); end
        else put_pair(m_run + 1, 0, 1, wtag);
        m_run = 0;
      end else if (m_run == 31) begin
        put_pair(31, 0, 0, wtag); m_run = 0;
      end else begin
        m_run++;
      end
    end
  endtask

  task automatic send_stream(string wtag, string vtag);
    model(wtag, vtag);
    for (int i = 0; i < stim.size(); i++) begin
      @(negedge clk);
      enc_valid = 1'b1;
      enc_data  = 16'(stim[i]);
      enc_last  = (i == stim.size() - 1);
      #5;
      while (!enc_ready) begin
        @(negedge clk);
        #5;
      end
    end
    @(negedge clk);
    enc_valid = 1'b0;
    enc_last  = 1'b0;
    enc_data  = '0;
  endtask

  task automatic drain(string tag);
    for (int k = 0; k < 2000 && (exp_w.size() != 0 || exp_v.size() != 0); k++) @(negedge clk);
    checks++;
    if (exp_w.size() != 0 || exp_v.size() != 0) begin
      fails++;
      $display("FAIL %s stream not fully produced: actual pending words=%0d values=%0d expected 0/0",
               tag, exp_w.size(), exp_v.size());
    end
  endtask

  // word monitor
  initial begin
    forever begin
      @(negedge clk); #5;
      if (rst_n && wout_valid && wout_ready) begin
        checks++;
        if (exp_w.size() == 0) begin
          fails++;
          $display("FAIL R4 unexpected word: actual=%h expected=none", wout_data);
        end else begin
          logic [63:0] e;
          string t;
          e = exp_w.pop_front();
          t = exp_wtag.pop_front();
          if (wout_data !== e) begin
            fails++;
            $display("FAIL %s packed word: actual=%h expected=%h", t, wout_data, e);
          end
        end
      end
    end
  end

  // value monitor with hold check
  initial begin
    logic        pend = 1'b0;
    logic [16:0] held = '0;
    forever begin
      @(negedge clk); #5;
      if (rst_n) begin
        if (pend) begin
          checks++;
          if (!dec_valid || {dec_last, dec_data} !== held) begin
            fails++;
            $display("FAIL R8 stalled value changed: actual=%b/%h expected=1/%h", dec_valid, {dec_last, dec_data}, held);
          end
        end
        pend = dec_valid && !dec_ready;
        held = {dec_last, dec_data};
        if (dec_valid && dec_ready) begin
          checks++;
          if (exp_v.size() == 0) begin
            fails++;
            $display("FAIL R9 unexpected value: actual=%h expected=none", {dec_last, dec_data});
          end else begin
            logic [16:0] e;
            string t;
            e = exp_v.pop_front();
            t = exp_vtag.pop_front();
            if ({dec_last, dec_data} !== e) begin
              fails++;
              $display("FAIL %s rebuilt value {last,data}: actual=%h expected=%h", t, {dec_last, dec_data}, e);
            end
          end
        end
      end
    end
  end

  // consumer throttle
  initial begin
    logic [15:0] lf = 16'hACE1;
    forever begin
      @(negedge clk);
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      dec_ready = throttle_en ? lf[0] : 1'b1;
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog: actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] g;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #5;
    checks++;
    if (!(enc_ready && !wout_valid && !dec_valid && win_ready)) begin
      fails++;
      $display("FAIL R6 reset state: actual ready=%b wv=%b dv=%b wr=%b expected 1/0/0/1",
               enc_ready, wout_valid, dec_valid, win_ready);
    end

    stim = '{5, 0, 0, 7, 0, 9};
    send_stream("R2", "R9"); drain("R2");

    stim.delete();
    for (int i = 0; i < 40; i++) stim.push_back(0);
    stim.push_back(3);
    send_stream("R3", "R9"); drain("R3");

    stim = '{4, 0, 0, 0};
    send_stream("R5", "R7"); drain("R5");

    stim.delete(); stim.push_back(1);
    for (int i = 0; i < 32; i++) stim.push_back(0);
    send_stream("R5", "R7"); drain("R5");

    stim = '{0};
    send_stream("R6", "R7"); drain("R6");

    stim = '{11, 22, 33, 44, 55, 66, 16'h8000};
    send_stream("R4", "R9"); drain("R4");

    stim.delete(); stim.push_back(2);
    for (int i = 0; i < 31; i++) stim.push_back(0);
    send_stream("R5", "R7"); drain("R5");

    throttle_en = 1'b1;
    stim.delete();
    g = 16'h1D2C;
    for (int i = 0; i < 300; i++) begin
      g = {g[14:0], g[15] ^ g[13] ^ g[12] ^ g[10]};
      stim.push_back(g[2:0] == 3'd0 ? int'(g | 16'd1) : 0);
    end
    send_stream("R1", "R8"); drain("R8");

    stim.delete();
    for (int i = 0; i < 100; i++) stim.push_back(0);
    send_stream("R3", "R9"); drain("R9");
    throttle_en = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule